// File: doc/BRIEF.md
# Numbered Packet Framer

This block turns a command request into a framed byte stream for a UART transmitter. Before each request, the requester writes the body bytes one by one into a load port. The block stores them and keeps a running byte sum. The requester then presents a command code and an in-response-to number. When the block accepts the request, it stamps the packet with a transmit serial number taken from an internal counter. It then emits the frame one byte at a time over a valid/ready handshake.

The checksum byte comes early in the frame, before the bytes it covers. Because of this, the block sums the body as it is loaded and adds the header bytes in the cycle the request is accepted. Transmission can then begin at once. The serial number counter skips zero, which stays free to mark a packet that answers nothing.

In the cycle after acceptance, the block reports the serial number it assigned on a strobed output. A requester can use it to record which of its requests are still waiting for an answer.

Top module: `pktx_framer`

## Requirements
- R1: After reset the serial counter holds 1, so the first packet carries TXSN 1; no packet ever carries TXSN 0.
- R2: Each accepted request takes the current counter value as its TXSN and advances the counter by one, so back-to-back packets carry consecutive numbers.
- R3: A packet stamped 255 is followed by one stamped 1 (the counter skips 0 when it wraps).
- R4: The frame leaves in this order: start byte 0x21, checksum, TXSN, IRSN, command, body length, then the body bytes in load order.
- R5: The checksum byte equals the sum modulo 256 of every byte that follows it in the frame: TXSN, IRSN, command, length and body.
- R6: The IRSN byte is `req_irsn` passed unchanged: 0 for an originated packet, or the number of the request being answered.
- R7: The length byte equals the number of body bytes stored since the previous packet ended; a packet with no loads is six bytes long.
- R8: Load bytes beyond `BODY_MAX` are dropped; the length saturates at `BODY_MAX` and the first `BODY_MAX` bytes are sent.
- R9: A request is accepted only while idle. `busy` is high and `req_ready` low from acceptance until the UART takes the last byte. Requests and loads presented meanwhile have no effect, and neither does a load in the acceptance cycle.
- R10: While `tx_valid` is high and `tx_ready` low, `tx_valid` stays high and `tx_data` does not change.
- R11: `sn_stb` is high for exactly the one cycle after acceptance, with `sn_value` equal to the TXSN placed in that packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_valid | input | 1 | Store `load_data` as the next body byte (idle only) |
| load_data | input | 8 | Body byte |
| req_valid | input | 1 | Packet request |
| req_ready | output | 1 | High when a request can be accepted |
| req_cmd | input | 8 | Command code |
| req_irsn | input | 8 | In-response-to serial number, 0 if originated |
| tx_valid | output | 1 | Byte available to the UART |
| tx_ready | input | 1 | UART takes the byte this cycle |
| tx_data | output | 8 | Frame byte |
| busy | output | 1 | A frame is in progress |
| sn_stb | output | 1 | Assigned serial number is valid |
| sn_value | output | 8 | Serial number assigned to the packet just accepted |

## Verification
The framer is tried with a range of frames: empty bodies, one-byte bodies, mid-length bodies and full bodies, with zero and nonzero IRSN values. It is also tried with a UART that is always ready and with one that stalls every second, third or fourth cycle.

A checksum error caused by a missing header byte shows up only when that byte is nonzero, and the stall patterns show whether data drifts under backpressure. Overfilling the load port separates saturation from wrap-around of the length. Poking requests and loads during a frame, then sending an empty packet, shows whether anything leaked into the counter or the buffer. A run of more than 255 packets exposes a counter that emits 0 on wrap, and a reset in mid-run shows that the counter returns to 1.

// File: rtl/pktx_pkg.sv
package pktx_pkg;

  localparam logic [7:0] START_BYTE = 8'h21;

  typedef enum logic [2:0] {
    FLD_START, FLD_CSUM, FLD_TXSN, FLD_IRSN, FLD_CMND, FLD_BLEN, FLD_BODY
  } fld_e;

  // Successor of a serial number; zero is reserved and skipped.
  function automatic logic [7:0] serial_after(input logic [7:0] cur);
    logic [7:0] inc;
    inc = cur + 8'd1;
    return (inc == 8'd0) ? 8'd1 : inc;
  endfunction

  // Checksum: header bytes plus precomputed body sum, modulo 256.
  function automatic logic [7:0] frame_sum(input logic [7:0] txsn,
                                           input logic [7:0] irsn,
                                           input logic [7:0] cmnd,
                                           input logic [7:0] blen,
                                           input logic [7:0] body);
    return txsn + irsn + cmnd + blen + body;
  endfunction

  // Which frame field a byte position holds.
  function automatic fld_e field_of(input int unsigned pos);
    case (pos)
      0:       return FLD_START;
      1:       return FLD_CSUM;
      2:       return FLD_TXSN;
      3:       return FLD_IRSN;
      4:       return FLD_CMND;
      5:       return FLD_BLEN;
      default: return FLD_BODY;
    endcase
  endfunction

endpackage

// File: rtl/pktx_serial_ctr.sv
module pktx_serial_ctr
  import pktx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  output logic [7:0] sn_cur
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sn_cur <= 8'd1;
    else if (take) sn_cur <= serial_after(sn_cur);
  end

  assert_sn_nonzero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sn_cur != 8'd0);

  assert_sn_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(sn_cur));

  assert_sn_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && sn_cur == 8'hFF) |=> sn_cur == 8'd1);

endmodule

// File: rtl/pktx_body_store.sv
module pktx_body_store
  import pktx_pkg::*;
#(
  parameter int BODY_MAX = 16,
  parameter int CNT_W    = $clog2(BODY_MAX + 1),
  parameter int IDX_W    = $clog2(BODY_MAX + 6)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             clr,
  input  logic [IDX_W-1:0] rd_off,
  output logic [7:0]       rd_data,
  output logic [CNT_W-1:0] count,
  output logic [7:0]       body_sum
);

  localparam int DEPTH = 1 << IDX_W;

  logic [7:0] mem [DEPTH];
  logic       full;
  logic       wr_accept;

  assign full      = (count == CNT_W'(BODY_MAX));
  assign wr_accept = wr_en && !full;
  assign rd_data   = mem[rd_off];

  always_ff @(posedge clk) begin
    if (wr_accept) mem[IDX_W'(count)] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      body_sum <= 8'd0;
    end else if (clr) begin
      count    <= '0;
      body_sum <= 8'd0;
    end else if (wr_accept) begin
      count    <= count + CNT_W'(1);
      body_sum <= body_sum + wr_data;
    end
  end

  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(BODY_MAX));

  assert_full_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !clr) |=> ($stable(count) && $stable(body_sum)));

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0 && body_sum == 8'd0));

endmodule

// File: rtl/pktx_emit.sv
module pktx_emit
  import pktx_pkg::*;
#(
  parameter int BODY_MAX = 16,
  parameter int CNT_W    = $clog2(BODY_MAX + 1),
  parameter int IDX_W    = $clog2(BODY_MAX + 6)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       csum_in,
  input  logic [7:0]       txsn_in,
  input  logic [7:0]       irsn_in,
  input  logic [7:0]       cmnd_in,
  input  logic [CNT_W-1:0] blen_in,
  input  logic [7:0]       body_byte,
  output logic [IDX_W-1:0] body_off,
  input  logic             tx_ready,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  output logic             busy,
  output logic             done
);

  logic [IDX_W-1:0] pos;
  logic [7:0]       csum_q, txsn_q, irsn_q, cmnd_q;
  logic [CNT_W-1:0] blen_q;
  logic [IDX_W-1:0] last_pos;
  logic             byte_taken;
  fld_e             fld;

  assign last_pos   = IDX_W'(blen_q) + IDX_W'(5);
  assign tx_valid   = busy;
  assign byte_taken = busy && tx_ready;
  assign done       = byte_taken && (pos == last_pos);
  assign body_off   = pos - IDX_W'(6);
  assign fld        = field_of(32'(pos));

  always_comb begin
    case (fld)
      FLD_START: tx_data = START_BYTE;
      FLD_CSUM:  tx_data = csum_q;
      FLD_TXSN:  tx_data = txsn_q;
      FLD_IRSN:  tx_data = irsn_q;
      FLD_CMND:  tx_data = cmnd_q;
      FLD_BLEN:  tx_data = 8'(blen_q);
      default:   tx_data = body_byte;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      pos    <= '0;
      csum_q <= 8'd0;
      txsn_q <= 8'd0;
      irsn_q <= 8'd0;
      cmnd_q <= 8'd0;
      blen_q <= '0;
    end else if (start && !busy) begin
      busy   <= 1'b1;
      pos    <= '0;
      csum_q <= csum_in;
      txsn_q <= txsn_in;
      irsn_q <= irsn_in;
      cmnd_q <= cmnd_in;
      blen_q <= blen_in;
    end else if (done) begin
      busy <= 1'b0;
      pos  <= '0;
    end else if (byte_taken) begin
      pos <= pos + IDX_W'(1);
    end
  end

  assert_hold_under_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  assert_frame_opens_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> tx_data == START_BYTE);

  assert_done_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  assert_pos_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> pos <= last_pos);

endmodule

// File: rtl/pktx_framer.sv
module pktx_framer
  import pktx_pkg::*;
#(
  parameter int BODY_MAX = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_valid,
  input  logic [7:0] load_data,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [7:0] req_cmd,
  input  logic [7:0] req_irsn,
  output logic       tx_valid,
  input  logic       tx_ready,
  output logic [7:0] tx_data,
  output logic       busy,
  output logic       sn_stb,
  output logic [7:0] sn_value
);

  localparam int CNT_W = $clog2(BODY_MAX + 1);
  localparam int IDX_W = $clog2(BODY_MAX + 6);

  logic             accept;
  logic             load_ok;
  logic             frame_done;
  logic [7:0]       sn_cur;
  logic [7:0]       csum_next;
  logic [CNT_W-1:0] body_cnt;
  logic [7:0]       body_sum;
  logic [IDX_W-1:0] body_off;
  logic [7:0]       body_byte;

  assign req_ready = !busy;
  assign accept    = req_valid && !busy;
  assign load_ok   = load_valid && !busy && !accept;
  assign csum_next = frame_sum(sn_cur, req_irsn, req_cmd, 8'(body_cnt), body_sum);

  pktx_serial_ctr u_sn (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (accept),
    .sn_cur (sn_cur)
  );

  pktx_body_store #(.BODY_MAX(BODY_MAX), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (load_ok),
    .wr_data  (load_data),
    .clr      (frame_done),
    .rd_off   (body_off),
    .rd_data  (body_byte),
    .count    (body_cnt),
    .body_sum (body_sum)
  );

  pktx_emit #(.BODY_MAX(BODY_MAX), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_emit (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .csum_in   (csum_next),
    .txsn_in   (sn_cur),
    .irsn_in   (req_irsn),
    .cmnd_in   (req_cmd),
    .blen_in   (body_cnt),
    .body_byte (body_byte),
    .body_off  (body_off),
    .tx_ready  (tx_ready),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .busy      (busy),
    .done      (frame_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sn_stb   <= 1'b0;
      sn_value <= 8'd0;
    end else begin
      sn_stb <= accept;
      if (accept) sn_value <= sn_cur;
    end
  end

  assert_stb_at_open_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sn_stb |-> (busy && tx_data == START_BYTE));

  assert_stb_nonzero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sn_stb |-> sn_value != 8'd0);

  assert_stb_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sn_stb |=> !sn_stb);

  assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !frame_done) |=> ($stable(sn_cur) && busy));

endmodule

// File: tb/pktx_framer_test.sv
module pktx_framer_test;

  localparam int BODY_MAX = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_valid = 1'b0;
  logic [7:0] load_data = 8'd0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [7:0] req_cmd = 8'd0;
  logic [7:0] req_irsn = 8'd0;
  logic       tx_valid;
  logic       tx_ready = 1'b0;
  logic [7:0] tx_data;
  logic       busy;
  logic       sn_stb;
  logic [7:0] sn_value;

  int checks = 0;
  int fails = 0;
  logic [7:0] exp_sn = 8'd1;

  always #5 clk = ~clk;

  pktx_framer #(.BODY_MAX(BODY_MAX)) uut (
    .clk(clk), .rst_n(rst_n),
    .load_valid(load_valid), .load_data(load_data),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_irsn(req_irsn),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .busy(busy), .sn_stb(sn_stb), .sn_value(sn_value)
  );

  // cmd, irsn, loads, seed, stall period
  localparam logic [39:0] VECS [6] = '{
    40'h63_00_00_10_00,
    40'h64_00_03_A0_00,
    40'h05_51_08_33_01,
    40'h7F_02_10_FF_02,
    40'h80_FE_01_01_03,
    40'h11_00_0C_5A_00
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_packet(input logic [7:0] cmd, input logic [7:0] irsn,
                            input int nload, input logic [7:0] seed,
                            input int stall, input bit poke);
    logic [7:0] exp_b [BODY_MAX + 6];
    logic [7:0] held;
    logic [7:0] s;
    int blen;
    int got;
    int cyc;
    bit stalled;
    bit rdy;
    for (int k = 0; k < nload; k++) begin
      @(negedge clk);
      load_valid = 1'b1;
      load_data  = seed + 8'(k * 37);
    end
    @(negedge clk);
    load_valid = 1'b0;
    chk("R9 req_ready idle", {7'd0, req_ready}, 8'd1);
    req_valid = 1'b1;
    req_cmd   = cmd;
    req_irsn  = irsn;
    @(negedge clk);
    req_valid = 1'b0;
    blen = (nload > BODY_MAX) ? BODY_MAX : nload;
    exp_b[0] = 8'h21;
    exp_b[2] = exp_sn;
    exp_b[3] = irsn;
    exp_b[4] = cmd;
    exp_b[5] = 8'(blen);
    for (int k = 0; k < blen; k++) exp_b[6 + k] = seed + 8'(k * 37);
    s = 8'd0;
    for (int k = 2; k < 6 + blen; k++) s = s + exp_b[k];
    exp_b[1] = s;
    chk("R11 sn_stb", {7'd0, sn_stb}, 8'd1);
    chk("R11 sn_value (R2 numbering)", sn_value, exp_sn);
    chk("R1 txsn nonzero", {7'd0, (sn_value != 8'd0)}, 8'd1);
    chk("R9 busy after accept", {7'd0, busy}, 8'd1);
    exp_sn = (exp_sn == 8'hFF) ? 8'd1 : exp_sn + 8'd1;
    got = 0;
    cyc = 0;
    stalled = 1'b0;
    held = 8'd0;
    while (got < 6 + blen) begin
      if (cyc == 1) chk("R11 strobe one cycle", {7'd0, sn_stb}, 8'd0);
      if (poke) begin
        req_valid  = 1'b1;
        load_valid = 1'b1;
        load_data  = 8'hEE;
        chk("R9 req_ready low while busy", {7'd0, req_ready}, 8'd0);
      end
      chk("R10 tx_valid held", {7'd0, tx_valid}, 8'd1);
      if (stalled) chk("R10 data stable under stall", tx_data, held);
      rdy = (stall == 0) || ((cyc % (stall + 1)) == stall);
      if (rdy) begin
        case (got)
          0: chk("R4 start byte", tx_data, exp_b[got]);
          1: chk("R5 checksum", tx_data, exp_b[got]);
          2: chk("R2 txsn", tx_data, exp_b[got]);
          3: chk("R6 irsn", tx_data, exp_b[got]);
          4: chk("R4 command", tx_data, exp_b[got]);
          5: chk("R7 length", tx_data, exp_b[got]);
          default: chk("R4 body byte", tx_data, exp_b[got]);
        endcase
        got++;
      end
      tx_ready = rdy;
      stalled  = !rdy;
      held     = tx_data;
      cyc++;
      @(negedge clk);
    end
    tx_ready   = 1'b0;
    req_valid  = 1'b0;
    load_valid = 1'b0;
    chk("R9 busy drops after last byte", {7'd0, busy}, 8'd0);
    chk("R9 tx_valid drops", {7'd0, tx_valid}, 8'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 busy in reset", {7'd0, busy}, 8'd0);
    chk("R11 no strobe in reset", {7'd0, sn_stb}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 idle after reset", {7'd0, req_ready}, 8'd1);
    chk("R10 tx_valid idle", {7'd0, tx_valid}, 8'd0);

    // Table walk; first packet checks R1 (TXSN 1), later ones R2..R7, R10
    for (int v = 0; v < 6; v++) begin
      run_packet(VECS[v][39:32], VECS[v][31:24], int'(VECS[v][23:16]),
                 VECS[v][15:8], int'(VECS[v][7:0]), 1'b0);
    end

    // R8: overfill the load port
    run_packet(8'h42, 8'h07, BODY_MAX + 3, 8'h09, 1, 1'b0);

    // R9: requests and loads during a frame are ignored
    run_packet(8'h22, 8'h00, 4, 8'h70, 2, 1'b1);
    // R7: nothing leaked into the buffer, so this frame is six bytes
    run_packet(8'h23, 8'h00, 0, 8'h00, 0, 1'b0);

    // R3: run the counter past 255
    while (exp_sn != 8'hFF) run_packet(8'h01, 8'h00, 0, 8'h00, 0, 1'b0);
    run_packet(8'h02, 8'h33, 2, 8'h44, 0, 1'b0);
    chk("R3 counter wrapped to 1", exp_sn, 8'd1);
    run_packet(8'h03, 8'h00, 1, 8'h55, 0, 1'b0);

    // R1: reset mid-run restores the counter to 1
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    exp_sn = 8'd1;
    run_packet(8'h04, 8'h00, 2, 8'h66, 0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule